// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

The block is a watchdog counter clocked in a slow timer domain that is represented here by a single-cycle `tick_i` enable at roughly 32 kHz. Each tick that the prescaler passes moves an up-counter one step. The counter starts from a programmable load value. When it steps past all-ones it reloads, raises a reset request and records an overflow event. A second event records when the counter lands on a programmable match value. Either event can drive the interrupt line.

Software cannot start or stop the counter with a single write. It has to write an ordered pair of key words to the key register. A write to the trigger register reloads the counter, but only when the new value differs from the one already held. Writes to the timer-domain registers take a fixed number of bus clocks to land. While a write is in flight, a per-register pending flag tells software that it has not landed yet. A self-clearing soft-reset bit returns the whole block to its power-up state.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, or once a soft reset completes, every register reads 0. The counter is stopped, `irq_o` is 0 and `wdt_rst_o` is 0.
- R2: Writing 0x0000BBBB to KEY (offset 0x20) and then 0x00004444 as the very next KEY write starts the counter.
- R3: Writing 0x0000AAAA to KEY and then 0x00005555 as the very next KEY write stops the counter. While the counter is stopped, COUNT (offset 0x10) holds its value whatever happens on `tick_i`.
- R4: If a KEY write breaks a pair (a different value between the two words, or a mismatched second word), the sequence returns to idle and the run state does not change.
- R5: When a write to TRIG (offset 0x18) lands with a value that differs from the held one, COUNT reloads from LOAD (offset 0x14) and the prescaler phase clears. A write with the same value leaves COUNT unchanged.
- R6: PRESCALE (offset 0x0C) has bit 3 as the enable and bits 2:0 as the exponent p. While the counter runs and the prescaler is enabled, COUNT advances once per 2^p ticks. With the enable clear, COUNT advances on every tick.
- R7: A write to PRESCALE, LOAD, TRIG, DELAY (offset 0x1C) or KEY sets that register's flag in PEND (offset 0x24) on the next cycle. The flags sit at bits 0, 1, 2, 3 and 4 in that order. Each flag clears when the write lands, SYNC_CYC clocks after the write.
- R8: A step past 0xFFFFFFFF reloads COUNT from LOAD. It also pulses `wdt_rst_o` for exactly one clock and sets bit 0 of ISTAT (offset 0x04).
- R9: A step that makes COUNT equal DELAY sets bit 1 of ISTAT.
- R10: `irq_o` is high whenever an ISTAT bit and the matching IEN bit (offset 0x08) are both set. Writing 1 to an ISTAT bit clears it.
- R11: Writing 1 to bit 0 of CFG (offset 0x00) starts a soft reset. Bit 0 reads 1 for SRST_CYC clocks and then clears itself, and the block is left in its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow timer-domain tick enable, one clock wide |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |
| wdt_rst_o | output | 1 | One-clock reset request on overflow |

## Verification
The bench breaks key pairs in both directions. A design that acted on the first word alone, or that kept a half-finished pair alive across a stray value, would change the run state when it should not. It writes the trigger twice with the same value and expects no reload, which catches a design that reloads on every write. Random exponent and tick counts expose an off-by-one in the divide. A load just below all-ones checks that the delay match, the overflow reload and the single-clock reset pulse land on the exact tick. A wrong wrap value or a stretched pulse would show up there.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam int NSLOT    = 5;
   localparam int SL_PRE   = 0;
   localparam int SL_LOAD  = 1;
   localparam int SL_TRIG  = 2;
   localparam int SL_DLY   = 3;
   localparam int SL_KEY   = 4;

   localparam logic [3:0] W_CFG   = 4'd0;
   localparam logic [3:0] W_ISTAT = 4'd1;
   localparam logic [3:0] W_IEN   = 4'd2;
   localparam logic [3:0] W_PRE   = 4'd3;
   localparam logic [3:0] W_COUNT = 4'd4;
   localparam logic [3:0] W_LOAD  = 4'd5;
   localparam logic [3:0] W_TRIG  = 4'd6;
   localparam logic [3:0] W_DLY   = 4'd7;
   localparam logic [3:0] W_KEY   = 4'd8;
   localparam logic [3:0] W_PEND  = 4'd9;

   localparam logic [31:0] KEY_STOP_A  = 32'h0000_AAAA;
   localparam logic [31:0] KEY_STOP_B  = 32'h0000_5555;
   localparam logic [31:0] KEY_START_A = 32'h0000_BBBB;
   localparam logic [31:0] KEY_START_B = 32'h0000_4444;

   typedef enum logic [1:0] {K_IDLE, K_STOP_ARMED, K_START_ARMED} key_st_e;

   function automatic logic [3:0] slot_word(input int idx);
      case (idx)
         SL_PRE:  return W_PRE;
         SL_LOAD: return W_LOAD;
         SL_TRIG: return W_TRIG;
         SL_DLY:  return W_DLY;
         default: return W_KEY;
      endcase
   endfunction
endpackage

// File: rtl/kwd_sync_slot.sv
module kwd_sync_slot #(
   parameter int W   = 32,
   parameter int DLY = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic         pend_o,
   output logic         apply_o,
   output logic [W-1:0] data_o
);
   localparam int TW = (DLY < 2) ? 1 : $clog2(DLY);

   if (DLY < 1) begin : g_bad_dly
      $error("kwd_sync_slot: DLY must be at least 1");
   end

   logic [TW-1:0] tmr;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_o <= 1'b0;
         tmr    <= '0;
         data_o <= '0;
      end else if (clr_i) begin
         pend_o <= 1'b0;
         tmr    <= '0;
         data_o <= '0;
      end else if (wr_i) begin
         pend_o <= 1'b1;
         tmr    <= TW'(DLY - 1);
         data_o <= wdata_i;
      end else if (pend_o) begin
         if (tmr == '0) pend_o <= 1'b0;
         else           tmr    <= tmr - 1'b1;
      end
   end

   assign apply_o = pend_o && (tmr == '0);

   // R7: a write always leaves the pending flag raised on the next cycle
   p_pend_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
      wr_i |=> pend_o);
endmodule

// File: rtl/kwd_keyfsm.sv
module kwd_keyfsm
   import kwd_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        clr_i,
   input  logic        key_vld_i,
   input  logic [31:0] key_i,
   output logic        run_o
);
   key_st_e st;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st    <= K_IDLE;
         run_o <= 1'b0;
      end else if (clr_i) begin
         st    <= K_IDLE;
         run_o <= 1'b0;
      end else if (key_vld_i) begin
         if (st == K_STOP_ARMED && key_i == KEY_STOP_B) begin
            run_o <= 1'b0;
            st    <= K_IDLE;
         end else if (st == K_START_ARMED && key_i == KEY_START_B) begin
            run_o <= 1'b1;
            st    <= K_IDLE;
         end else if (key_i == KEY_STOP_A)  st <= K_STOP_ARMED;
         else if (key_i == KEY_START_A)     st <= K_START_ARMED;
         else                               st <= K_IDLE;
      end
   end

   // R4: the run state moves only when a key write lands
   p_run_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
      !key_vld_i |=> $stable(run_o));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
   parameter int CNT_W = 32,
   parameter int PTV_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             pre_en_i,
   input  logic [PTV_W-1:0] ptv_i,
   input  logic [CNT_W-1:0] load_i,
   input  logic [CNT_W-1:0] delay_i,
   input  logic             reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o,
   output logic             dly_o
);
   localparam int PRE_W = (1 << PTV_W) - 1;

   if (PTV_W < 1 || PTV_W > 4) begin : g_bad_ptv
      $error("kwd_counter: PTV_W out of range");
   end

   logic [PRE_W-1:0] pcnt;
   logic [PRE_W-1:0] plim;
   logic             hit;
   logic [CNT_W-1:0] nxt;

   assign plim = ~({PRE_W{1'b1}} << ptv_i);
   assign hit  = !pre_en_i || (pcnt == plim);
   assign nxt  = (cnt_o == '1) ? load_i : cnt_o + 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o <= '0;
         pcnt  <= '0;
         ovf_o <= 1'b0;
         dly_o <= 1'b0;
      end else if (clr_i) begin
         cnt_o <= '0;
         pcnt  <= '0;
         ovf_o <= 1'b0;
         dly_o <= 1'b0;
      end else begin
         ovf_o <= 1'b0;
         dly_o <= 1'b0;
         if (reload_i) begin
            cnt_o <= load_i;
            pcnt  <= '0;
         end else if (tick_i && run_i) begin
            if (hit) begin
               pcnt  <= '0;
               cnt_o <= nxt;
               ovf_o <= (cnt_o == '1);
               dly_o <= (nxt == delay_i);
            end else begin
               pcnt <= pcnt + 1'b1;
            end
         end
      end
   end

   // R3: a stopped counter without a reload holds its value
   p_count_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
      (!run_i && !reload_i) |=> $stable(cnt_o));
   // R8: an overflow pulse only follows a running cycle
   p_ovf_needs_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
      ovf_o |-> $past(run_i && tick_i));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import kwd_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int SYNC_CYC = 3,
   parameter int SRST_CYC = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_o,
   output logic              wdt_rst_o
);
   localparam int CNT_W = 32;
   localparam int PTV_W = 3;
   localparam int SRW   = $clog2(SRST_CYC + 1);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("keyed_watchdog: ADDR_W must cover the register map");
   end
   if (SRST_CYC < 1) begin : g_bad_srst
      $error("keyed_watchdog: SRST_CYC must be at least 1");
   end

   logic [3:0]       word;
   logic             wr_en;
   logic [SRW-1:0]   srst_cnt;
   logic             clr;
   logic [NSLOT-1:0] pend, apply;
   logic [31:0]      sdata [NSLOT];
   logic [3:0]       pre_q;
   logic [31:0]      load_q, delay_q, trig_q;
   logic [1:0]       ien_q, ist_q;
   logic             run, reload, ovf_p, dly_p;
   logic [31:0]      cnt;

   assign word  = bus_addr_i[5:2];
   assign wr_en = bus_sel_i && bus_wr_i;
   assign clr   = (srst_cnt != '0);

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      kwd_sync_slot #(.W(32), .DLY(SYNC_CYC)) i_slot (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .clr_i   (clr),
         .wr_i    (wr_en && word == slot_word(i)),
         .wdata_i (bus_wdata_i),
         .pend_o  (pend[i]),
         .apply_o (apply[i]),
         .data_o  (sdata[i])
      );
   end

   assign reload = apply[SL_TRIG] && (sdata[SL_TRIG] != trig_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         srst_cnt <= '0;
      end else if (clr) begin
         srst_cnt <= srst_cnt - 1'b1;
      end else if (wr_en && word == W_CFG && bus_wdata_i[0]) begin
         srst_cnt <= SRW'(SRST_CYC);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q   <= '0;
         load_q  <= '0;
         delay_q <= '0;
         trig_q  <= '0;
         ien_q   <= '0;
         ist_q   <= '0;
      end else if (clr) begin
         pre_q   <= '0;
         load_q  <= '0;
         delay_q <= '0;
         trig_q  <= '0;
         ien_q   <= '0;
         ist_q   <= '0;
      end else begin
         if (apply[SL_PRE])  pre_q   <= sdata[SL_PRE][3:0];
         if (apply[SL_LOAD]) load_q  <= sdata[SL_LOAD];
         if (apply[SL_DLY])  delay_q <= sdata[SL_DLY];
         if (apply[SL_TRIG]) trig_q  <= sdata[SL_TRIG];
         if (wr_en && word == W_IEN) ien_q <= bus_wdata_i[1:0];
         ist_q <= (ist_q & ~((wr_en && word == W_ISTAT) ? bus_wdata_i[1:0] : 2'b00))
                  | {dly_p, ovf_p};
      end
   end

   kwd_keyfsm i_keys (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .key_vld_i (apply[SL_KEY]),
      .key_i     (sdata[SL_KEY]),
      .run_o     (run)
   );

   kwd_counter #(.CNT_W(CNT_W), .PTV_W(PTV_W)) i_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .tick_i   (tick_i),
      .run_i    (run),
      .pre_en_i (pre_q[3]),
      .ptv_i    (pre_q[2:0]),
      .load_i   (load_q),
      .delay_i  (delay_q),
      .reload_i (reload),
      .cnt_o    (cnt),
      .ovf_o    (ovf_p),
      .dly_o    (dly_p)
   );

   assign wdt_rst_o = ovf_p;
   assign irq_o     = |(ist_q & ien_q);

   always_comb begin
      case (word)
         W_CFG:   bus_rdata_o = {31'd0, clr};
         W_ISTAT: bus_rdata_o = {30'd0, ist_q};
         W_IEN:   bus_rdata_o = {30'd0, ien_q};
         W_PRE:   bus_rdata_o = {28'd0, pre_q};
         W_COUNT: bus_rdata_o = cnt;
         W_LOAD:  bus_rdata_o = load_q;
         W_TRIG:  bus_rdata_o = trig_q;
         W_DLY:   bus_rdata_o = delay_q;
         W_PEND:  bus_rdata_o = {{(32-NSLOT){1'b0}}, pend};
         default: bus_rdata_o = '0;
      endcase
   end

   // R8: the reset request is recorded as an overflow event on the next cycle
   p_rst_logs_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || clr)
      wdt_rst_o |=> ist_q[0]);
   // R11: a soft reset leaves the counter at zero once it has ended
   p_srst_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(clr) |-> (cnt == '0 && !run));
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
   localparam int SYNC = 3;
   localparam int SRST = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, wrst;

   int n_vec = 0, n_bad = 0, rst_seen = 0;
   logic [31:0] trig_m = 0;

   localparam logic [5:0] A_CFG = 6'h00, A_IST = 6'h04, A_IEN = 6'h08, A_PRE = 6'h0C,
      A_CNT = 6'h10, A_LOAD = 6'h14, A_TRIG = 6'h18, A_DLY = 6'h1C, A_KEY = 6'h20,
      A_PEND = 6'h24;

   always #2.5 clk = ~clk;

   keyed_watchdog #(.ADDR_W(6), .SYNC_CYC(SYNC), .SRST_CYC(SRST)) i_keyed_watchdog (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_sel_i(sel), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .wdt_rst_o(wrst));

   always @(negedge clk) if (wrst) rst_seen++;

   function automatic logic [31:0] exp_count(input logic [31:0] ld, input int n, input int p);
      return ld + 32'(n >> p);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_raw(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
      @(negedge clk); sel = 0; wr = 0;
   endtask

   task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
      wr_raw(a, d);
      repeat (SYNC + 2) @(negedge clk);
   endtask

   task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1;
         @(negedge clk); tick = 0;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic key_pair(input logic [31:0] a, input logic [31:0] b);
      wr_reg(A_KEY, a); wr_reg(A_KEY, b);
   endtask

   task automatic new_trig();
      trig_m = trig_m + 1; wr_reg(A_TRIG, trig_m);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v, c0, ld;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd_reg(A_CNT, v);  check("R1 count", v, 0);
      rd_reg(A_LOAD, v); check("R1 load", v, 0);
      rd_reg(A_PEND, v); check("R1 pend", v, 0);
      rd_reg(A_IST, v);  check("R1 istat", v, 0);
      check("R1 irq", {31'd0, irq}, 0);
      check("R1 rst", {31'd0, wrst}, 0);

      // R7 pending flag for trigger (bit 2)
      trig_m = 1;
      wr_raw(A_TRIG, trig_m);
      rd_reg(A_PEND, v); check("R7 pend set", v, 32'h4);
      repeat (SYNC + 2) @(negedge clk);
      rd_reg(A_PEND, v); check("R7 pend clear", v, 0);

      // R2 / R6 start with prescale 2^2
      wr_reg(A_LOAD, 32'h100);
      wr_reg(A_PRE, 32'hA);
      new_trig();
      key_pair(32'hBBBB, 32'h4444);
      ticks(10);
      rd_reg(A_CNT, v); check("R2 R6 start+prescale", v, exp_count(32'h100, 10, 2));

      // R3 stop freezes count
      key_pair(32'hAAAA, 32'h5555);
      rd_reg(A_CNT, c0);
      ticks(5);
      rd_reg(A_CNT, v); check("R3 stopped", v, c0);

      // R4 broken start sequences leave it stopped
      wr_reg(A_KEY, 32'hBBBB); wr_reg(A_KEY, 32'h1234); wr_reg(A_KEY, 32'h4444);
      wr_reg(A_KEY, 32'hBBBB); wr_reg(A_KEY, 32'hAAAA); wr_reg(A_KEY, 32'h4444);
      ticks(3);
      rd_reg(A_CNT, v); check("R4 still stopped", v, c0);
      // R4 broken stop sequence leaves it running
      wr_reg(A_PRE, 32'h0);
      key_pair(32'hBBBB, 32'h4444);
      new_trig();
      wr_reg(A_KEY, 32'hAAAA); wr_reg(A_KEY, 32'h7777); wr_reg(A_KEY, 32'h5555);
      ticks(4);
      rd_reg(A_CNT, v); check("R4 still running", v, 32'h104);

      // R5 same trigger value: no reload; new value: reload
      key_pair(32'hAAAA, 32'h5555);
      wr_reg(A_TRIG, trig_m);
      rd_reg(A_CNT, v); check("R5 same trigger", v, 32'h104);
      new_trig();
      rd_reg(A_CNT, v); check("R5 new trigger", v, 32'h100);

      // R6 random prescale and tick counts
      for (int it = 0; it < 8; it++) begin
         int p, n;
         p  = int'($urandom_range(7, 0));
         n  = int'($urandom_range(300, 1));
         ld = $urandom() & 32'h7FFF_FFFF;
         wr_reg(A_PRE, 32'(8 + p));
         wr_reg(A_LOAD, ld);
         new_trig();
         key_pair(32'hBBBB, 32'h4444);
         ticks(n);
         rd_reg(A_CNT, v); check("R6 random divide", v, exp_count(ld, n, p));
         key_pair(32'hAAAA, 32'h5555);
      end

      // R8 R9 R10 overflow and delay match
      wr_reg(A_PRE, 32'h0);
      wr_reg(A_IEN, 32'h1);
      wr_reg(A_LOAD, 32'hFFFF_FFF0);
      wr_reg(A_DLY, 32'hFFFF_FFF5);
      new_trig();
      key_pair(32'hBBBB, 32'h4444);
      rst_seen = 0;
      ticks(4);
      rd_reg(A_IST, v); check("R9 no early match", v, 0);
      ticks(1);
      rd_reg(A_IST, v); check("R9 match", v, 32'h2);
      check("R10 masked delay", {31'd0, irq}, 0);
      ticks(10);
      check("R8 no early reset", 32'(rst_seen), 0);
      ticks(1);
      rd_reg(A_CNT, v); check("R8 wrap reload", v, 32'hFFFF_FFF0);
      check("R8 single pulse", 32'(rst_seen), 1);
      rd_reg(A_IST, v); check("R8 ovf status", v, 32'h3);
      check("R10 irq on ovf", {31'd0, irq}, 1);
      wr_reg(A_IST, 32'h1);
      rd_reg(A_IST, v); check("R10 w1c ovf", v, 32'h2);
      check("R10 irq cleared", {31'd0, irq}, 0);
      wr_reg(A_IST, 32'h2);
      rd_reg(A_IST, v); check("R10 w1c dly", v, 0);

      // R11 soft reset
      wr_raw(A_CFG, 32'h1);
      rd_reg(A_CFG, v); check("R11 busy", v, 1);
      repeat (SRST + 2) @(negedge clk);
      rd_reg(A_CFG, v);  check("R11 self clear", v, 0);
      rd_reg(A_LOAD, v); check("R11 R1 load", v, 0);
      rd_reg(A_IEN, v);  check("R11 R1 ien", v, 0);
      ticks(3);
      rd_reg(A_CNT, v);  check("R11 R1 stopped", v, 0);

      finish_run();
   end
endmodule